// File: doc/BRIEF.md
# Page Access Guard with Fault Status Capture

This block decides whether a single memory access may use a page table entry that a table walker has already fetched. The access is described by its kind (load, store or instruction fetch), by whether it comes from user or supervisor code, and by its virtual address. The block combines the 3-bit access field of the entry with a 3-bit access index built from the request. From these it produces a fault code and the read, write and execute rights that may be installed in a translation cache. It also raises one of two trap requests: one for instruction fetches and one for data accesses.

All checking logic is combinational. Two registers hold the most recent fault. The status register packs the access index, the fault code, a valid flag and an overwrite flag. The address register keeps the faulting virtual address. Software reads either register through a small read port, and reading the status register clears it. A global no-fault control bit lets user accesses continue past a failed check and suppresses all trap requests. A separate trap-enable input also gates the trap requests.

Top module: `page_access_guard`

## Requirements
- R1: The access index is {write, fetch, supervisor} with the write flag in bit 2, the fetch flag in bit 1 and the supervisor flag in bit 0. `req_kind` is encoded 00 load, 01 store, 10 fetch, and 11 is treated as a load. `req_user`=1 marks a user access.
- R2: `fault_code` is 0 (allowed), 8 (protection) or 12 (privilege), taken from the access field in `pte_word[4:2]`. A user access to field value 6 or 7 gives 12. Otherwise the code is 8 when the right the access needs is missing from the supervisor or user rights of R4, and 0 when it is present.
- R3: When `ctl_nofault`=1 and the access is a user access, a nonzero code causes no fault event: no status update, no trap, and rights come from the table.
- R4: Rights are R4-table values indexed by the access field. Supervisor rights: 0:R 1:RW 2:RX 3:RWX 4:X 5:RW 6:RX 7:RWX. User rights are the same for 0 to 4, then 5:R, 6:none, 7:none.
- R5: `perm_write` is 0 whenever the modified bit `pte_word[6]` is 0.
- R6: All three rights outputs are 0 in a cycle with a fault event. A fault event is `req_valid`=1 with a nonzero code that R3 does not waive.
- R7: After a fault event, the status register holds (index<<5) | code | 2, ORed with the overwrite flag of R8. The address register holds the request's virtual address. Both appear one cycle later.
- R8: If the status register is nonzero when a fault event occurs, bit 0 of the new status value is 1. Otherwise bit 0 is 0.
- R9: A trap request is raised only in a fault-event cycle with `ctl_nofault`=0 and `ctl_traps_en`=1. It is `trap_ifetch` for fetches and `trap_data` for other accesses, and never both at once.
- R10: `sw_rdata` shows the status register (zero-extended) when `sw_rd_sel`=0 and the address register when `sw_rd_sel`=1. A read of the status register clears it on the next edge. A fault event in that same cycle wins over the clear. Reading the address register changes nothing.
- R11: After reset both registers read 0 and no trap request is active while `req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is being checked this cycle |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| req_user | input | 1 | 1 for user, 0 for supervisor |
| req_vaddr | input | VA_W | Virtual address of the access |
| pte_word | input | 32 | Page table entry: access field [4:2], modified bit [6] |
| ctl_nofault | input | 1 | Global no-fault control bit |
| ctl_traps_en | input | 1 | Traps currently enabled |
| fault_code | output | 4 | Check result: 0, 8 or 12 |
| perm_read | output | 1 | Read right granted |
| perm_write | output | 1 | Write right granted |
| perm_exec | output | 1 | Execute right granted |
| trap_ifetch | output | 1 | Instruction-fault trap request |
| trap_data | output | 1 | Data-fault trap request |
| sw_rd_en | input | 1 | Software read strobe |
| sw_rd_sel | input | 1 | 0 selects status, 1 selects address |
| sw_rdata | output | VA_W | Read data |

## Verification
The overwrite flag is the hardest state to reach. It appears only when a second fault lands before software has drained the first one. Its interaction with a status read in the same cycle is also hard to hit. The random stream keeps status reads rare and faults frequent, so chained faults happen often. Directed sequences then place two faults back to back, a fault on the same cycle as a status read, and an address-register read between faults. Each of these shows whether the flag appears, whether the clear is dropped, and whether the address read leaves the status untouched.

// File: rtl/pag_pkg.sv
package pag_pkg;

    localparam int PTE_W   = 32;
    localparam int ACC_W   = 3;
    localparam int CODE_W  = 4;
    localparam int IDX_W   = 3;
    localparam int FSR_W   = 8;
    localparam int NACC    = 1 << ACC_W;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_ALT   = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [23:0]      ppn;
        logic             cacheable;
        logic             modified;
        logic             referenced;
        logic [ACC_W-1:0] acc;
        logic [1:0]       etype;
    } pte_t;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    localparam logic [CODE_W-1:0] FC_OK   = 4'd0;
    localparam logic [CODE_W-1:0] FC_PROT = 4'd8;
    localparam logic [CODE_W-1:0] FC_PRIV = 4'd12;

    // One row per access index; nibble n holds the code for access field n.
    localparam logic [NACC*CODE_W-1:0] FAULT_ROWS [NACC] = '{
        32'hCC08_0000,
        32'h0008_0000,
        32'hCC80_0088,
        32'h0080_0088,
        32'hCC88_0808,
        32'h0808_0808,
        32'hCC88_0888,
        32'h0888_0888
    };

    // Rights per access field, three bits {r,w,x} each, field 0 lowest.
    localparam logic [NACC*3-1:0] RIGHTS_SUP  = 24'b111_101_110_001_111_101_110_100;
    localparam logic [NACC*3-1:0] RIGHTS_USER = 24'b000_000_100_001_111_101_110_100;

    function automatic logic [IDX_W-1:0] make_index(input acc_kind_e kind, input logic user);
        logic wr;
        logic fe;
        wr = (kind == KIND_STORE);
        fe = (kind == KIND_FETCH);
        return {wr, fe, ~user};
    endfunction

    function automatic logic [FSR_W-1:0] status_word(input logic [IDX_W-1:0] idx,
                                                     input logic [CODE_W-1:0] code,
                                                     input logic ovw);
        return {idx, 1'b0, code} | 8'h02 | {7'd0, ovw};
    endfunction

endpackage

// File: rtl/pag_fault_matrix.sv
module pag_fault_matrix
    import pag_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [ACC_W-1:0]  acc,
    output logic [CODE_W-1:0] code
);
    logic [NACC*CODE_W-1:0] rows [NACC];

    for (genvar g = 0; g < NACC; g++) begin : g_row
        assign rows[g] = FAULT_ROWS[g];
    end

    always_comb begin
        code = rows[idx][acc*CODE_W +: CODE_W];
    end
endmodule

// File: rtl/pag_perm_table.sv
module pag_perm_table
    import pag_pkg::*;
(
    input  logic             user,
    input  logic [ACC_W-1:0] acc,
    input  logic             modified,
    output perm_t            perm
);
    perm_t base;

    always_comb begin
        if (user) base = perm_t'(RIGHTS_USER[acc*3 +: 3]);
        else      base = perm_t'(RIGHTS_SUP[acc*3 +: 3]);
        perm   = base;
        perm.w = base.w & modified;
    end
endmodule

// File: rtl/pag_status_regs.sv
module pag_status_regs
    import pag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_evt,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CODE_W-1:0] code,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              clr_status,
    output logic [FSR_W-1:0]  status_q,
    output logic [VA_W-1:0]   addr_q
);
    logic             ovw;
    logic [FSR_W-1:0] status_d;

    always_comb begin
        ovw      = (status_q != '0);
        status_d = status_word(idx, code, ovw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            addr_q   <= '0;
        end else if (fault_evt) begin
            status_q <= status_d;
            addr_q   <= vaddr;
        end else if (clr_status) begin
            status_q <= '0;
        end
    end
endmodule

// File: rtl/page_access_guard.sv
module page_access_guard
    import pag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic            req_user,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [31:0]     pte_word,
    input  logic            ctl_nofault,
    input  logic            ctl_traps_en,
    output logic [3:0]      fault_code,
    output logic            perm_read,
    output logic            perm_write,
    output logic            perm_exec,
    output logic            trap_ifetch,
    output logic            trap_data,
    input  logic            sw_rd_en,
    input  logic            sw_rd_sel,
    output logic [VA_W-1:0] sw_rdata
);
    localparam int PAD_W = VA_W - FSR_W;

    acc_kind_e         kind;
    pte_t              pte;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code;
    perm_t             tbl_perm;
    logic              waived;
    logic              fault_evt;
    logic              trap_req;
    logic [FSR_W-1:0]  status_q;
    logic [VA_W-1:0]   addr_q;

    always_comb begin
        kind = acc_kind_e'(req_kind);
        pte  = pte_t'(pte_word);
        idx  = make_index(kind, req_user);
    end

    pag_fault_matrix u_matrix (
        .idx  (idx),
        .acc  (pte.acc),
        .code (code)
    );

    pag_perm_table u_perm (
        .user     (req_user),
        .acc      (pte.acc),
        .modified (pte.modified),
        .perm     (tbl_perm)
    );

    always_comb begin
        waived      = ctl_nofault & req_user;
        fault_evt   = req_valid & (code != FC_OK) & ~waived;
        trap_req    = fault_evt & ~ctl_nofault & ctl_traps_en;
        trap_ifetch = trap_req & (kind == KIND_FETCH);
        trap_data   = trap_req & (kind != KIND_FETCH);
        fault_code  = code;
        perm_read   = tbl_perm.r & ~fault_evt;
        perm_write  = tbl_perm.w & ~fault_evt;
        perm_exec   = tbl_perm.x & ~fault_evt;
    end

    pag_status_regs #(.VA_W(VA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .fault_evt  (fault_evt),
        .idx        (idx),
        .code       (code),
        .vaddr      (req_vaddr),
        .clr_status (sw_rd_en & ~sw_rd_sel),
        .status_q   (status_q),
        .addr_q     (addr_q)
    );

    always_comb begin
        if (sw_rd_sel) sw_rdata = addr_q;
        else           sw_rdata = {{PAD_W{1'b0}}, status_q};
    end
endmodule

// File: rtl/pag_sva.sv
module pag_sva #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic            req_user,
    input logic [VA_W-1:0] req_vaddr,
    input logic [31:0]     pte_word,
    input logic            ctl_nofault,
    input logic [3:0]      fault_code,
    input logic            perm_write,
    input logic            trap_ifetch,
    input logic            trap_data,
    input logic            sw_rd_en,
    input logic            sw_rd_sel,
    input logic [7:0]      status_q,
    input logic [VA_W-1:0] addr_q
);
    logic evt;
    assign evt = req_valid && fault_code != 4'd0 && !(ctl_nofault && req_user);

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        fault_code == 4'd0 || fault_code == 4'd8 || fault_code == 4'd12);

    // R5
    write_needs_mod_chk: assert property (@(posedge clk) disable iff (rst)
        perm_write |-> pte_word[6]);

    // R9
    trap_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_ifetch, trap_data}));

    // R9
    ifetch_kind_chk: assert property (@(posedge clk) disable iff (rst)
        trap_ifetch |-> req_kind == 2'b10);

    // R7
    trap_logs_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_ifetch || trap_data) |=> status_q[1]);

    // R7
    addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> addr_q == $past(req_vaddr));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_rd_en && !sw_rd_sel && !evt) |=> status_q == 8'd0);
endmodule

bind page_access_guard pag_sva #(.VA_W(VA_W)) u_pag_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_user    (req_user),
    .req_vaddr   (req_vaddr),
    .pte_word    (pte_word),
    .ctl_nofault (ctl_nofault),
    .fault_code  (fault_code),
    .perm_write  (perm_write),
    .trap_ifetch (trap_ifetch),
    .trap_data   (trap_data),
    .sw_rd_en    (sw_rd_en),
    .sw_rd_sel   (sw_rd_sel),
    .status_q    (status_q),
    .addr_q      (addr_q)
);

// File: tb/tb_page_access_guard.sv
module tb_page_access_guard;
    localparam int VA_W = 32;

    logic            clk = 0;
    logic            rst;
    logic            req_valid;
    logic [1:0]      req_kind;
    logic            req_user;
    logic [VA_W-1:0] req_vaddr;
    logic [31:0]     pte_word;
    logic            ctl_nofault;
    logic            ctl_traps_en;
    logic [3:0]      fault_code;
    logic            perm_read, perm_write, perm_exec;
    logic            trap_ifetch, trap_data;
    logic            sw_rd_en, sw_rd_sel;
    logic [VA_W-1:0] sw_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0]      m_fsr;
    logic [VA_W-1:0] m_far;

    always #2 clk = ~clk;

    page_access_guard #(.VA_W(VA_W)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] rights(input logic user, input logic [2:0] a);
        logic r, w, x;
        r = (a != 3'd4);
        w = a[0];
        x = (a == 3'd2) || (a == 3'd3) || (a == 3'd4) || (a == 3'd6) || (a == 3'd7);
        if (user && a == 3'd5) begin w = 1'b0; x = 1'b0; end
        if (user && a >= 3'd6) begin r = 1'b0; w = 1'b0; x = 1'b0; end
        return {r, w, x};
    endfunction

    function automatic logic [3:0] exp_code(input logic [1:0] k, input logic user, input logic [2:0] a);
        logic [2:0] rt;
        logic need;
        if (user && a >= 3'd6) return 4'd12;
        rt = rights(user, a);
        if (k == 2'b01)      need = rt[1];
        else if (k == 2'b10) need = rt[0];
        else                 need = rt[2];
        return need ? 4'd0 : 4'd8;
    endfunction

    function automatic logic [2:0] exp_idx(input logic [1:0] k, input logic user);
        return {k == 2'b01, k == 2'b10, !user};
    endfunction

    // Drive one cycle at negedge, check outputs, then advance the model after posedge.
    task automatic step(input logic v, input logic [1:0] k, input logic u, input logic [31:0] va,
                        input logic [31:0] pte, input logic nf, input logic te,
                        input logic rd, input logic sel);
        logic [3:0] c;
        logic       evt;
        logic [2:0] p;
        @(negedge clk);
        req_valid = v; req_kind = k; req_user = u; req_vaddr = va; pte_word = pte;
        ctl_nofault = nf; ctl_traps_en = te; sw_rd_en = rd; sw_rd_sel = sel;
        #1;
        c   = exp_code(k, u, pte[4:2]);
        evt = v && c != 0 && !(nf && u);
        p   = rights(u, pte[4:2]);
        p[1] = p[1] & pte[6];
        if (evt) p = 3'b000;
        chk("R2 code", {28'd0, fault_code}, {28'd0, c});
        chk("R4/R5/R6 rights", {29'd0, perm_read, perm_write, perm_exec}, {29'd0, p});
        chk("R9 trap", {30'd0, trap_ifetch, trap_data},
            {30'd0, evt && !nf && te && k == 2'b10, evt && !nf && te && k != 2'b10});
        chk("R10 rdata", sw_rdata, sel ? m_far : {24'd0, m_fsr});
        @(posedge clk);
        if (evt) begin
            m_fsr = {exp_idx(k, u), 5'd0} | {4'd0, c} | 8'h02 | {7'd0, m_fsr != 0};
            m_far = va;
        end else if (rd && !sel) begin
            m_fsr = 8'd0;
        end
    endtask

    task automatic read_fsr(input string req, input logic [7:0] exp);
        @(negedge clk);
        req_valid = 0; sw_rd_en = 0; sw_rd_sel = 0;
        #1;
        chk(req, sw_rdata, {24'd0, exp});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; req_valid = 0; req_kind = 0; req_user = 0; req_vaddr = 0; pte_word = 0;
        ctl_nofault = 0; ctl_traps_en = 1; sw_rd_en = 0; sw_rd_sel = 0;
        m_fsr = 0; m_far = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R11 reset state
        chk("R11 status", sw_rdata, 32'd0);
        sw_rd_sel = 1; #1;
        chk("R11 address", sw_rdata, 32'd0);
        chk("R11 traps", {30'd0, trap_ifetch, trap_data}, 32'd0);

        // R1 user store to read-only field: index 100, code 8
        step(1, 2'b01, 1, 32'h1000_0040, 32'h0000_0040, 0, 1, 0, 0);
        read_fsr("R1 R7 status", 8'h8A);
        // R8 second fault before read: supervisor fetch, field 0 -> idx 011
        step(1, 2'b10, 0, 32'h2000_0000, 32'h0000_0000, 0, 1, 0, 0);
        read_fsr("R8 overwrite", 8'h6B);
        // R10 address read leaves status
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 1);
        read_fsr("R10 addr read keeps status", 8'h6B);
        // R10 status read clears
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 0);
        read_fsr("R10 clear", 8'h00);
        // R10 fault with read same cycle: user load field 6 -> code 12, idx 000
        step(1, 2'b00, 0, 32'h3, 32'h0000_0010, 0, 1, 0, 0);
        step(1, 2'b00, 1, 32'h4, 32'h0000_0018, 0, 1, 1, 0);
        read_fsr("R10 fault wins", 8'h0F);
        // R3 user no-fault override: no status change
        step(1, 2'b11, 1, 32'h5, 32'h0000_001C, 1, 1, 1, 0);
        read_fsr("R3 waived", 8'h00);
        // R9 supervisor fault with no-fault set: logged, no trap
        step(1, 2'b01, 0, 32'h6, 32'h0000_0000, 1, 1, 0, 0);
        read_fsr("R9 logged", 8'hAA);
        // R5 modified clear withholds write
        step(1, 2'b00, 0, 32'h7, 32'h0000_000C, 0, 1, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, 2'($urandom), 1'($urandom), $urandom, $urandom,
                 ($urandom % 4) == 0, ($urandom % 5) != 0, ($urandom % 6) == 0, 1'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule